// File: doc/BRIEF.md
# Prescaled 64-bit Machine Timer

This block is the core of a free-running 64-bit timer that raises one interrupt when the count reaches a compare value. A prescaler divides the clock. Each time the prescaler wraps, the counter adds a programmable step. Both the prescaler and the counter advance only while a global run bit is set.

Software reaches the block through a flat register port that has an address, write data, a write strobe and combinational read data. The 64-bit count and the 64-bit compare value are each exposed as two 32-bit words. The interrupt path has an enable, a sticky status bit and a test trigger. The compare value comes out of reset at all ones, so the interrupt stays quiet until software programs it.

Top module: `mtm_timer`

## Requirements
- R1: The run bit (bit 0 of the run word) resets to 0. While it is 0, neither the prescaler nor the count changes, except by software writes.
- R2: The setup word holds the divide value in bits 11:0, which reset to 0, and the step in bits 23:16, which reset to 1. All other bits of the setup word read as 0.
- R3: While running, the prescaler counts from 0 up to the divide value and then returns to 0. A tick is issued on the wrap cycle, so the block ticks once every divide+1 running cycles.
- R4: On each tick the 64-bit count grows by the zero-extended step, and the carry passes from the low word into the high word. Both count words reset to 0.
- R5: Both compare words reset to 0xFFFFFFFF. On every clock edge where the count is greater than or equal to the compare value, the status bit is set.
- R6: Writing a 1 to bit 0 of the status word clears the status bit. Writing a 0 has no effect. A hardware set in the same cycle wins over the clear.
- R7: The interrupt enable (bit 0) resets to 0. The interrupt output is high exactly when both the status bit and the enable are 1.
- R8: Writing a 1 to bit 0 of the test word sets the status bit at the next edge. The test word always reads 0.
- R9: A software write to a count word overrides the tick increment in that cycle. The count word that is not written holds its value in that cycle.
- R10: A read of an unmapped address returns 0xFFFFFFFF. A write to an unmapped address changes nothing.
- R11: The byte offsets are: run 0x00, setup 0x04, count low 0x08, count high 0x0C, compare low 0x10, compare high 0x14, enable 0x18, status 0x1C, test 0x20. Any other address, including one that is not word aligned, is unmapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 6 | Byte address of the register access |
| reg_wdata_i | input | 32 | Write data |
| reg_we_i | input | 1 | Write strobe, one write per high cycle |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Timer interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 12-bit divide field and an 8-bit step field. With these values the carry from the low word into the high word can be reached in a few cycles by preloading the low word near 0xFFFFFFFF and using a step of 3. A divide value of 3 brings an exact two-tick window into an eight-cycle run. Every address of the 6-bit space can be decoded, including an unmapped one just past the test word.

// File: rtl/mtm_pkg.sv
package mtm_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_RUN    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SETUP  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_CNT_LO = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IE     = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_TEST   = 6'h20;
  localparam int NUM_REGS = 9;

  // count plus zero-extended step, full width
  function automatic logic [63:0] mtm_advance(input logic [63:0] cnt, input logic [7:0] step);
    return cnt + {56'd0, step};
  endfunction

  // prescaler wrap condition
  function automatic logic mtm_wraps(input logic [11:0] cur, input logic [11:0] lim);
    return cur >= lim;
  endfunction
endpackage

// File: rtl/mtm_prescaler.sv
module mtm_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] div_q;

  assign tick_o = run_i && (div_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (run_i)  div_q <= tick_o ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/mtm_counter.sv
module mtm_counter #(
  parameter int WORD_W = 32,
  parameter int STEP_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [STEP_W-1:0]   step_i,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic [WORD_W-1:0]   wdata_i,
  output logic [2*WORD_W-1:0] count_o
);
  import mtm_pkg::*;
  localparam int CNT_W = 2 * WORD_W;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc = mtm_advance(cnt_q, step_i);
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (lo_we_i || hi_we_i) begin
      if (lo_we_i) cnt_q[WORD_W-1:0]     <= wdata_i;
      if (hi_we_i) cnt_q[CNT_W-1:WORD_W] <= wdata_i;
    end else if (tick_i) begin
      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/mtm_irq.sv
module mtm_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic test_set_i,
  input  logic sw_clr_i,
  input  logic enable_i,
  output logic status_o,
  output logic irq_o
);
  logic stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= 1'b0;
    else         stat_q <= (stat_q && !sw_clr_i) || hw_set_i || test_set_i;
  end

  assign status_o = stat_q;
  assign irq_o    = stat_q & enable_i;
endmodule

// File: rtl/mtm_timer.sv
module mtm_timer #(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 32,
  parameter int PRE_W  = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  input  logic              reg_we_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  import mtm_pkg::*;
  localparam int CNT_W    = 2 * WORD_W;
  localparam int STEP_LSB = 16;

  logic              run_q, ie_q;
  logic [PRE_W-1:0]  limit_q;
  logic [STEP_W-1:0] step_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  count;
  logic              tick, match, status;
  logic              cnt_lo_we, cnt_hi_we, test_set, stat_clr;
  logic [NUM_REGS-1:0] hit;
  logic [ADDR_W-1:0]   ofs [NUM_REGS];

  assign ofs[0] = OFS_RUN;    assign ofs[1] = OFS_SETUP;
  assign ofs[2] = OFS_CNT_LO; assign ofs[3] = OFS_CNT_HI;
  assign ofs[4] = OFS_CMP_LO; assign ofs[5] = OFS_CMP_HI;
  assign ofs[6] = OFS_IE;     assign ofs[7] = OFS_STAT;
  assign ofs[8] = OFS_TEST;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    assign hit[g] = (reg_addr_i == ofs[g]);
  end

  assign cnt_lo_we = reg_we_i && hit[2];
  assign cnt_hi_we = reg_we_i && hit[3];
  assign test_set  = reg_we_i && hit[8] && reg_wdata_i[0];
  assign stat_clr  = reg_we_i && hit[7] && reg_wdata_i[0];
  assign match     = count >= cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      ie_q    <= 1'b0;
      limit_q <= '0;
      step_q  <= STEP_W'(1);
      cmp_q   <= '1;
    end else if (reg_we_i) begin
      if (hit[0]) run_q <= reg_wdata_i[0];
      if (hit[1]) begin
        limit_q <= reg_wdata_i[PRE_W-1:0];
        step_q  <= reg_wdata_i[STEP_LSB +: STEP_W];
      end
      if (hit[4]) cmp_q[WORD_W-1:0]     <= reg_wdata_i;
      if (hit[5]) cmp_q[CNT_W-1:WORD_W] <= reg_wdata_i;
      if (hit[6]) ie_q <= reg_wdata_i[0];
    end
  end

  mtm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_q), .limit_i(limit_q), .tick_o(tick)
  );

  mtm_counter #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .step_i(step_q),
    .lo_we_i(cnt_lo_we), .hi_we_i(cnt_hi_we), .wdata_i(reg_wdata_i), .count_o(count)
  );

  mtm_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .hw_set_i(match), .test_set_i(test_set),
    .sw_clr_i(stat_clr), .enable_i(ie_q), .status_o(status), .irq_o(irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (1'b1)
      hit[0]: reg_rdata_o[0] = run_q;
      hit[1]: begin
        reg_rdata_o[PRE_W-1:0]          = limit_q;
        reg_rdata_o[STEP_LSB +: STEP_W] = step_q;
      end
      hit[2]: reg_rdata_o = count[WORD_W-1:0];
      hit[3]: reg_rdata_o = count[CNT_W-1:WORD_W];
      hit[4]: reg_rdata_o = cmp_q[WORD_W-1:0];
      hit[5]: reg_rdata_o = cmp_q[CNT_W-1:WORD_W];
      hit[6]: reg_rdata_o[0] = ie_q;
      hit[7]: reg_rdata_o[0] = status;
      hit[8]: reg_rdata_o = '0;
      default: reg_rdata_o = '1;
    endcase
  end
endmodule

// File: rtl/mtm_checker.sv
module mtm_checker #(
  parameter int WORD_W = 32,
  parameter int STEP_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                run_q,
  input logic                tick,
  input logic                match,
  input logic                status,
  input logic                irq_o,
  input logic                cnt_lo_we,
  input logic                cnt_hi_we,
  input logic                test_set,
  input logic [STEP_W-1:0]   step_q,
  input logic [WORD_W-1:0]   reg_wdata_i,
  input logic [2*WORD_W-1:0] count
);
  p_hold_stopped_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !cnt_lo_we && !cnt_hi_we) |=> $stable(count));

  p_tick_needs_run_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |-> run_q);

  p_step_add_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_lo_we && !cnt_hi_we) |=>
      count == $past(count) + {{(2*WORD_W-STEP_W){1'b0}}, $past(step_q)});

  p_match_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> status);

  p_irq_needs_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status);

  p_test_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_set |=> status);

  p_write_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_lo_we |=> count[WORD_W-1:0] == $past(reg_wdata_i));
endmodule

bind mtm_timer mtm_checker #(.WORD_W(WORD_W), .STEP_W(STEP_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_q(run_q), .tick(tick), .match(match),
  .status(status), .irq_o(irq_o), .cnt_lo_we(cnt_lo_we), .cnt_hi_we(cnt_hi_we),
  .test_set(test_set), .step_q(step_q), .reg_wdata_i(reg_wdata_i), .count(count)
);

// File: tb/sim_mtm_timer.sv
module sim_mtm_timer;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] A_RUN = 6'h00, A_SET = 6'h04, A_CLO = 6'h08, A_CHI = 6'h0C,
                         A_MLO = 6'h10, A_MHI = 6'h14, A_IE = 6'h18, A_ST = 6'h1C,
                         A_TST = 6'h20, A_BAD = 6'h24;

  logic clk = 0, rst_n = 0, we = 0, irq;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mtm_timer u0 (.clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
                .reg_we_i(we), .reg_rdata_o(rdata), .irq_o(irq));

  // behavioural reference model
  logic [63:0] m_cnt, m_cmp;
  int m_ps, m_pre, m_step;
  bit m_run, m_ie, m_st;

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      A_RUN: return {31'd0, m_run};
      A_SET: return (32'(m_step) << 16) | 32'(m_pre);
      A_CLO: return m_cnt[31:0];
      A_CHI: return m_cnt[63:32];
      A_MLO: return m_cmp[31:0];
      A_MHI: return m_cmp[63:32];
      A_IE:  return {31'd0, m_ie};
      A_ST:  return {31'd0, m_st};
      A_TST: return 32'd0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = '1; m_ps = 0; m_pre = 0; m_step = 1;
      m_run = 0; m_ie = 0; m_st = 0;
    end else begin
      bit tk, hw, tset, clr;
      tk   = m_run && (m_ps >= m_pre);
      hw   = (m_cnt >= m_cmp);
      tset = we && addr == A_TST && wdata[0];
      clr  = we && addr == A_ST && wdata[0];
      if (hw || tset) m_st = 1; else if (clr) m_st = 0;
      if (m_run) m_ps = tk ? 0 : m_ps + 1;
      if (we && (addr == A_CLO || addr == A_CHI)) begin
        if (addr == A_CLO) m_cnt[31:0] = wdata;
        else m_cnt[63:32] = wdata;
      end else if (tk) m_cnt = m_cnt + 64'(m_step);
      if (we) case (addr)
        A_RUN: m_run = wdata[0];
        A_SET: begin m_pre = int'(wdata[11:0]); m_step = int'(wdata[23:16]); end
        A_MLO: m_cmp[31:0] = wdata;
        A_MHI: m_cmp[63:32] = wdata;
        A_IE:  m_ie = wdata[0];
        default: ;
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7-model-irq", {31'd0, irq}, {31'd0, m_run ? (m_st & m_ie) : (m_st & m_ie)});
      check("R11-model-read", rdata, m_read(addr));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    idle(3);
    rst_n = 1;
    idle(1);
    // reset state
    rd(A_RUN, v); check("R1 run reset", v, 0);
    rd(A_SET, v); check("R2 setup reset", v, 32'h0001_0000);
    rd(A_CLO, v); check("R4 count lo reset", v, 0);
    rd(A_MHI, v); check("R5 compare hi reset", v, 32'hFFFF_FFFF);
    rd(A_IE, v);  check("R7 enable reset", v, 0);
    rd(A_TST, v); check("R8 test reads zero", v, 0);
    rd(A_BAD, v); check("R10 unmapped read", v, 32'hFFFF_FFFF);
    rd(6'h05, v); check("R11 misaligned unmapped", v, 32'hFFFF_FFFF);
    check("R7 irq reset", {31'd0, irq}, 0);

    // run with step 1, then stop and hold
    wr(A_RUN, 1); idle(10);
    wr(A_RUN, 0);
    rd(A_CLO, v); idle(5); rd(A_CLO, v2);
    check("R1 hold while stopped", v2, v);
    check("R1 count advanced", {31'd0, v != 0}, 1);

    // divide 3, step 5: two ticks per eight cycles
    wr(A_SET, 32'h0005_0003); wr(A_RUN, 1);
    rd(A_CLO, v); idle(8); rd(A_CLO, v2);
    check("R3 R4 prescaled step", v2 - v, 10);
    wr(A_RUN, 0);

    // carry into upper word
    wr(A_SET, 32'h0003_0000);
    wr(A_CLO, 32'hFFFF_FFFE); wr(A_CHI, 0);
    rd(A_CLO, v); check("R9 written low word", v, 32'hFFFF_FFFE);
    wr(A_RUN, 1); idle(3); wr(A_RUN, 0);
    rd(A_CHI, v); check("R4 carry to high", v, 1);

    // write wins over increment while running
    wr(A_RUN, 1);
    wr(A_CLO, 32'h0000_1234);
    rd(A_CLO, v); check("R9 write beats tick", v, 32'h0000_1234);
    wr(A_CHI, 0);
    wr(A_RUN, 0);

    // unmapped write
    wr(A_BAD, 32'h0);
    rd(A_RUN, v); check("R10 unmapped write no effect", v, 0);

    // compare and interrupt
    wr(A_SET, 32'h0001_0000);
    wr(A_CLO, 0); wr(A_CHI, 0);
    wr(A_MHI, 0); wr(A_MLO, 20);
    wr(A_IE, 1); wr(A_RUN, 1);
    idle(30);
    check("R5 R7 irq after compare", {31'd0, irq}, 1);
    wr(A_ST, 1);
    rd(A_ST, v); check("R6 set wins over clear", v, 1);
    wr(A_RUN, 0);
    wr(A_MHI, 32'hFFFF_FFFF);
    wr(A_ST, 0);
    rd(A_ST, v); check("R6 writing zero no effect", v, 1);
    wr(A_ST, 1);
    rd(A_ST, v); check("R6 cleared", v, 0);
    check("R7 irq low after clear", {31'd0, irq}, 0);

    // test trigger with enable off, then on
    wr(A_IE, 0);
    wr(A_TST, 1);
    rd(A_ST, v); check("R8 test sets status", v, 1);
    check("R7 gated by enable", {31'd0, irq}, 0);
    rd(A_TST, v); check("R8 test reads zero after write", v, 0);
    wr(A_IE, 1);
    check("R7 irq with enable", {31'd0, irq}, 1);
    wr(A_ST, 1);
    idle(2);
    finish_run();
  end
endmodule